// File: doc/BRIEF.md
# Memory-to-Memory Block Transfer Engine

This block copies a programmed number of bytes from a source address range to a destination address range, with no processor involved once the copy is started. A small register port sets the source address, the destination address, the byte count and a control word. The control word carries the access width and one address-freeze bit for each side. A status word reports completion. The engine reads through a read master and writes through a write master. A small FIFO sits between the two masters, so the write side runs whenever the FIFO holds data, whatever state the read side is in.

Each master steps its address by the access width after every accepted beat. Either side can instead keep its address fixed, which suits a peripheral that has one data register, such as a serial transmitter. Both masters obey a wait input from the addressed slave. Either slave can also flag an end of packet, which closes the transfer early and leaves the bytes not yet written readable in the length register.

Top module: `sdma_engine`

## Requirements
- R1: After reset, reg_rdata reads zero for the length, control and status registers. rd_req and wr_req are low.
- R2: Register map (reg_addr): 0 source address, 1 destination address, 2 byte length, 3 control, 4 status, 5 beat count. Control bits: [2:0] width code, [3] freeze source, [4] freeze destination, [5] start, [6] clear. Reading the control register returns the busy flag in bit 5. Status bits: bit 0 done, bit 1 busy. The width code selects a step of 1, 2, 4, 8 or 16 bytes for codes 0 to 4; codes 5 to 7 behave as code 4. After each accepted beat of a side whose freeze bit is clear, that side's address register grows by the step.
- R3: A side whose freeze bit is set keeps its address unchanged for the whole transfer. The two bits act independently.
- R4: The length register counts bytes and drops by the step on each accepted write. When it reaches zero, done goes to 1 and busy to 0. Exactly length/step writes are made. A start with length zero sets done at once and makes no access.
- R5: The beat-count register reads the length shifted right by the effective width code.
- R6: No read is issued while the FIFO (depth 2) is full, or once length/step reads have been accepted.
- R7: A write is issued only when the FIFO holds data. The written words are the read words, in read order.
- R8: While wait is high, that side's request stays high and its address holds.
- R9: While busy, writes to the address, length and control registers are ignored, a repeated start included.
- R10: Writing the clear bit stops the engine, empties the FIFO, and zeroes the length, busy and done. Both requests go low.
- R11: rd_eop on an accepted read stops further reads. The beats already in the FIFO are still written, then done is set and the unwritten byte count remains in the length register.
- R12: wr_eop on an accepted write discards the FIFO contents, sets done, clears busy and leaves the residual length readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_wait | input | 1 | Read slave stall |
| rd_data | input | DATA_W | Read data, valid on the accepting cycle |
| rd_eop | input | 1 | Read slave end of packet, qualifies an accepted read |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data from the FIFO head |
| wr_wait | input | 1 | Write slave stall |
| wr_eop | input | 1 | Write slave end of packet, qualifies an accepted write |

## Verification
The properties assume a slave that returns read data in the same cycle in which it drops rd_wait, and end-of-packet flags that count only on an accepted beat. They also assume software leaves the control register alone while busy, except for the clear bit. The stimulus follows these rules. Wait inputs come from rotating bit patterns or explicit holds, each end-of-packet flag is raised only on the beat the bench is about to accept, and every programmed length is a whole number of beats.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    typedef enum logic [2:0] {
        REG_RADDR = 3'd0,
        REG_WADDR = 3'd1,
        REG_LEN   = 3'd2,
        REG_CTRL  = 3'd3,
        REG_STAT  = 3'd4,
        REG_BEATS = 3'd5
    } reg_sel_e;

    localparam int CTRL_RFIX = 3;
    localparam int CTRL_WFIX = 4;
    localparam int CTRL_GO   = 5;
    localparam int CTRL_CLR  = 6;
endpackage

// File: rtl/sdma_stride.sv
module sdma_stride #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int MAX_CODE = 4
) (
    input  logic [2:0]        code,
    input  logic              rfix,
    input  logic              wfix,
    output logic [ADDR_W-1:0] rinc,
    output logic [ADDR_W-1:0] winc,
    output logic [LEN_W-1:0]  step,
    output logic [2:0]        ecode
);
    logic [ADDR_W-1:0] unit;

    // codes beyond the port width collapse to the widest access
    assign ecode = (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
    assign unit  = ADDR_W'(1) << ecode;
    assign step  = LEN_W'(1) << ecode;
    assign rinc  = rfix ? '0 : unit;
    assign winc  = wfix ? '0 : unit;
endmodule

// File: rtl/sdma_fifo.sv
module sdma_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp_q];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        wp_d  = do_push ? nxt(wp_q) : wp_q;
        rp_d  = do_pop  ? nxt(rp_q) : rp_q;
        cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            wp_d  = '0;
            rp_d  = '0;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_BYTES = 16,
    parameter int FIFO_DEPTH = 2,
    localparam int DATA_W    = DATA_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_wait,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_eop,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_wait,
    input  logic              wr_eop
);
    localparam int MAX_CODE = $clog2(DATA_BYTES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              rd_term;
        logic [2:0]        code;
        logic              rfix;
        logic              wfix;
        logic [ADDR_W-1:0] raddr;
        logic [ADDR_W-1:0] waddr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rd_rem;
    } eng_t;

    eng_t s_d, s_q;

    logic [ADDR_W-1:0] rinc, winc;
    logic [LEN_W-1:0]  step, len_after, rem_after;
    logic [2:0]        ecode;
    logic              rd_fire, wr_fire, clr, fifo_flush;
    logic              fifo_full, fifo_empty;
    logic              busy, done, rfix, wfix;
    logic [2:0]        width_code;

    sdma_stride #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CODE(MAX_CODE)) u_stride (
        .code (s_q.code),
        .rfix (s_q.rfix),
        .wfix (s_q.wfix),
        .rinc (rinc),
        .winc (winc),
        .step (step),
        .ecode(ecode)
    );

    sdma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rd_fire && !clr),
        .pop  (wr_fire && !clr),
        .flush(fifo_flush),
        .din  (rd_data),
        .dout (wr_data),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    assign clr       = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[CTRL_CLR];
    assign rd_req    = s_q.busy && !s_q.rd_term && (s_q.rd_rem != '0) && !fifo_full;
    assign wr_req    = s_q.busy && !fifo_empty && (s_q.len != '0);
    assign rd_fire   = rd_req && !rd_wait;
    assign wr_fire   = wr_req && !wr_wait;
    assign len_after = (s_q.len > step) ? s_q.len - step : '0;
    assign rem_after = (s_q.rd_rem > step) ? s_q.rd_rem - step : '0;
    assign rd_addr   = s_q.raddr;
    assign wr_addr   = s_q.waddr;

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign rfix       = s_q.rfix;
    assign wfix       = s_q.wfix;
    assign width_code = s_q.code;

    always_comb begin
        s_d        = s_q;
        fifo_flush = 1'b0;
        if (clr) begin
            s_d.busy    = 1'b0;
            s_d.done    = 1'b0;
            s_d.rd_term = 1'b0;
            s_d.len     = '0;
            s_d.rd_rem  = '0;
            fifo_flush  = 1'b1;
        end else begin
            if (reg_wr && !s_q.busy) begin
                case (reg_addr)
                    REG_RADDR: s_d.raddr = reg_wdata[ADDR_W-1:0];
                    REG_WADDR: s_d.waddr = reg_wdata[ADDR_W-1:0];
                    REG_LEN:   s_d.len   = reg_wdata[LEN_W-1:0];
                    REG_CTRL: begin
                        s_d.code = reg_wdata[2:0];
                        s_d.rfix = reg_wdata[CTRL_RFIX];
                        s_d.wfix = reg_wdata[CTRL_WFIX];
                        if (reg_wdata[CTRL_GO]) begin
                            s_d.rd_term = 1'b0;
                            s_d.rd_rem  = s_q.len;
                            s_d.done    = (s_q.len == '0);
                            s_d.busy    = (s_q.len != '0);
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_fire) begin
                s_d.raddr  = s_q.raddr + rinc;
                s_d.rd_rem = rem_after;
                if (rd_eop) s_d.rd_term = 1'b1;
            end
            if (wr_fire) begin
                s_d.waddr = s_q.waddr + winc;
                s_d.len   = len_after;
                if ((len_after == '0) || wr_eop) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
                if (wr_eop) fifo_flush = 1'b1;
            end else if (s_q.busy && s_q.rd_term && fifo_empty) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            REG_RADDR: reg_rdata = 32'(s_q.raddr);
            REG_WADDR: reg_rdata = 32'(s_q.waddr);
            REG_LEN:   reg_rdata = 32'(s_q.len);
            REG_CTRL:  reg_rdata = {26'd0, s_q.busy, s_q.wfix, s_q.rfix, s_q.code};
            REG_STAT:  reg_rdata = {30'd0, s_q.busy, s_q.done};
            REG_BEATS: reg_rdata = 32'(s_q.len >> ecode);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              rd_req,
    input logic              rd_wait,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic              wr_wait,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              done,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              rfix,
    input logic              wfix,
    input logic [2:0]        width_code
);
    localparam int MAXC = $clog2(DATA_BYTES);

    logic clr_now;
    assign clr_now = reg_wr && (reg_addr == 3'd3) && reg_wdata[6];

    function automatic logic [ADDR_W-1:0] inc_of(input logic [2:0] c);
        return ADDR_W'(1) << ((int'(c) > MAXC) ? MAXC : int'(c));
    endfunction

    AST_RD_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !fifo_full); // R6
    AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !fifo_empty); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_req && !wr_req)); // R4
    AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_wait && rfix) |=> (rd_addr == $past(rd_addr))); // R3
    AST_WR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_wait && wfix) |=> (wr_addr == $past(wr_addr))); // R3
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_wait && !rfix && !clr_now) |=>
        (rd_addr == $past(rd_addr) + inc_of($past(width_code)))); // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_wait && !wfix && !clr_now) |=>
        (wr_addr == $past(wr_addr) + inc_of($past(width_code)))); // R2
    AST_RD_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_wait && !clr_now) |=> (rd_req && $stable(rd_addr))); // R8
    AST_WR_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_wait && !clr_now) |=> (wr_req && $stable(wr_addr))); // R8
    AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (!busy && !done && !rd_req && !wr_req)); // R10
endmodule

bind sdma_engine sdma_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_req    (rd_req),
    .rd_wait   (rd_wait),
    .rd_addr   (rd_addr),
    .wr_req    (wr_req),
    .wr_wait   (wr_wait),
    .wr_addr   (wr_addr),
    .busy      (busy),
    .done      (done),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .rfix      (rfix),
    .wfix      (wfix),
    .width_code(width_code)
);

// File: tb/tb_sdma_engine.sv
module tb_sdma_engine;
    import sdma_pkg::*;

    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rd_req, wr_req;
    logic [31:0]   rd_addr, wr_addr;
    logic          rd_wait = 1'b0, wr_wait = 1'b0;
    logic          rd_eop = 1'b0, wr_eop = 1'b0;
    logic [DW-1:0] rd_data, wr_data;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mdata(input logic [31:0] a);
        return {a, ~a, a ^ 32'h5A5A_5A5A, a + 32'h1111_1111};
    endfunction
    assign rd_data = mdata(rd_addr);

    sdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_wait(rd_wait),
        .rd_data(rd_data), .rd_eop(rd_eop),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_wait(wr_wait), .wr_eop(wr_eop)
    );

    // stimulus side state, written only by the initial block
    logic [7:0] rpat = '0, wpat = '0;
    logic       rd_hold = 1'b0, wr_hold = 1'b0;
    int         reop_at = -1, weop_at = -1, rbase = 0, wbase = 0;

    // beat log, written only by the monitor
    int            cyc = 0, rcnt = 0, wcnt = 0;
    logic [31:0]   ra_log [512];
    logic [31:0]   wa_log [512];
    logic [DW-1:0] wd_log [512];

    always @(negedge clk) begin
        cyc++;
        rd_wait = rd_hold | rpat[cyc % 8];
        wr_wait = wr_hold | wpat[cyc % 8];
        #1;
        rd_eop = (reop_at >= 0) && (rcnt - rbase == reop_at);
        wr_eop = (weop_at >= 0) && (wcnt - wbase == weop_at);
        if (rst_n && rd_req && !rd_wait) begin
            ra_log[rcnt] = rd_addr;
            rcnt++;
        end
        if (rst_n && wr_req && !wr_wait) begin
            wa_log[wcnt] = wr_addr;
            wd_log[wcnt] = wr_data;
            wcnt++;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        #3;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        #3;
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        #3;
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] st;
        for (int k = 0; k < 3000; k++) begin
            rreg(REG_STAT, st);
            if (st[0]) break;
        end
    endtask

    function automatic int eff(input logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    task automatic mark();
        @(negedge clk);
        #4;
        rbase = rcnt;
        wbase = wcnt;
    endtask

    typedef struct packed {
        logic [31:0] ra;
        logic [31:0] wa;
        logic [15:0] len;
        logic [2:0]  code;
        logic        rf;
        logic        wf;
        logic [7:0]  rp;
        logic [7:0]  wp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0000_2000, 16'd16, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00},
        '{32'h0000_1100, 32'h0000_2200, 16'd32, 3'd1, 1'b0, 1'b0, 8'h55, 8'h00},
        '{32'h0000_4000, 32'h0000_5000, 16'd64, 3'd2, 1'b1, 1'b0, 8'h00, 8'h33},
        '{32'h0000_6000, 32'h0000_7000, 16'd64, 3'd3, 1'b0, 1'b1, 8'h81, 8'h0F},
        '{32'h0000_8000, 32'h0000_9000, 16'd64, 3'd4, 1'b0, 1'b0, 8'h0F, 8'hF0},
        '{32'h0000_A000, 32'h0000_B000, 16'd8,  3'd3, 1'b0, 1'b0, 8'h00, 8'h00},
        '{32'h0000_C000, 32'h0000_D000, 16'd32, 3'd7, 1'b1, 1'b1, 8'h24, 8'h42}
    };

    task automatic run_vec(input vec_t v);
        logic [31:0] r;
        int beats, ri, wi;
        beats = int'(v.len) >> eff(v.code);
        ri = v.rf ? 0 : (1 << eff(v.code));
        wi = v.wf ? 0 : (1 << eff(v.code));
        rpat = v.rp; wpat = v.wp;
        mark();
        wreg(REG_RADDR, v.ra);
        wreg(REG_WADDR, v.wa);
        wreg(REG_LEN, 32'(v.len));
        wreg(REG_CTRL, {27'd0, v.wf, v.rf, v.code});
        rreg(REG_BEATS, r);
        chk("R5", "beat count", 128'(r), 128'(beats));
        wreg(REG_CTRL, {26'd0, 1'b1, v.wf, v.rf, v.code});
        wait_done();
        rreg(REG_STAT, r);
        chk("R4", "status after transfer", 128'(r), 128'(1));
        rreg(REG_LEN, r);
        chk("R4", "length at end", 128'(r), 128'(0));
        chk("R4", "write count", 128'(wcnt - wbase), 128'(beats));
        chk("R6", "read count", 128'(rcnt - rbase), 128'(beats));
        for (int i = 0; i < beats; i++) begin
            chk(v.wf ? "R3" : "R2", "write address", 128'(wa_log[wbase + i]),
                128'(v.wa + 32'(i * wi)));
            chk(v.rf ? "R3" : "R2", "read address", 128'(ra_log[rbase + i]),
                128'(v.ra + 32'(i * ri)));
            chk("R7", "write data", wd_log[wbase + i], mdata(v.ra + 32'(i * ri)));
        end
        rreg(REG_RADDR, r);
        chk(v.rf ? "R3" : "R2", "final source", 128'(r), 128'(v.ra + 32'(beats * ri)));
        rreg(REG_WADDR, r);
        chk(v.wf ? "R3" : "R2", "final destination", 128'(r), 128'(v.wa + 32'(beats * wi)));
        rpat = '0; wpat = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(REG_STAT, r);
        chk("R1", "status", 128'(r), 128'(0));
        rreg(REG_LEN, r);
        chk("R1", "length", 128'(r), 128'(0));
        rreg(REG_CTRL, r);
        chk("R1", "control", 128'(r), 128'(0));
        chk("R1", "requests", 128'({rd_req, wr_req}), 128'(0));

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4 zero length start
        mark();
        wreg(REG_LEN, 32'd0);
        wreg(REG_CTRL, 32'h22);
        repeat (3) @(negedge clk);
        rreg(REG_STAT, r);
        chk("R4", "zero length done", 128'(r), 128'(1));
        chk("R4", "zero length reads", 128'(rcnt - rbase), 128'(0));

        // R8 / R6 / R9 / R10 stall, full FIFO, ignored writes, clear
        rd_hold = 1'b1; wr_hold = 1'b1;
        mark();
        wreg(REG_RADDR, 32'h300);
        wreg(REG_WADDR, 32'h600);
        wreg(REG_LEN, 32'd64);
        wreg(REG_CTRL, 32'h22);
        repeat (3) @(negedge clk);
        #6;
        chk("R8", "read request held", 128'(rd_req), 128'(1));
        chk("R8", "read address held", 128'(rd_addr), 128'(32'h300));
        chk("R8", "no read during stall", 128'(rcnt - rbase), 128'(0));
        rd_hold = 1'b0;
        repeat (10) @(negedge clk);
        #6;
        chk("R6", "reads stop at full FIFO", 128'(rcnt - rbase), 128'(2));
        chk("R6", "no request while full", 128'(rd_req), 128'(0));
        held = wr_addr;
        repeat (3) @(negedge clk);
        #6;
        chk("R8", "write request held", 128'(wr_req), 128'(1));
        chk("R8", "write address held", 128'(wr_addr), 128'(held));
        wreg(REG_LEN, 32'h100);
        wreg(REG_CTRL, 32'h20);
        rreg(REG_LEN, r);
        chk("R9", "length write ignored", 128'(r), 128'(64));
        rreg(REG_CTRL, r);
        chk("R9", "control write ignored", 128'(r), 128'(32'h22));
        wreg(REG_CTRL, 32'h40);
        rreg(REG_STAT, r);
        chk("R10", "status cleared", 128'(r), 128'(0));
        rreg(REG_LEN, r);
        chk("R10", "length cleared", 128'(r), 128'(0));
        chk("R10", "requests low", 128'({rd_req, wr_req}), 128'(0));
        wr_hold = 1'b0;
        mark();
        wreg(REG_RADDR, 32'h10);
        wreg(REG_WADDR, 32'h20);
        wreg(REG_LEN, 32'd4);
        wreg(REG_CTRL, 32'h22);
        wait_done();
        chk("R10", "one write after clear", 128'(wcnt - wbase), 128'(1));
        chk("R10", "no stale FIFO data", wd_log[wbase], mdata(32'h10));

        // R11 read side end of packet
        mark();
        reop_at = 3;
        wreg(REG_RADDR, 32'hC00);
        wreg(REG_WADDR, 32'hD00);
        wreg(REG_LEN, 32'd64);
        wreg(REG_CTRL, 32'h22);
        wait_done();
        reop_at = -1;
        rreg(REG_STAT, r);
        chk("R11", "done after read eop", 128'(r), 128'(1));
        chk("R11", "reads", 128'(rcnt - rbase), 128'(4));
        chk("R11", "writes drained", 128'(wcnt - wbase), 128'(4));
        chk("R11", "last drained data", wd_log[wbase + 3], mdata(32'hC0C));
        rreg(REG_LEN, r);
        chk("R11", "residual length", 128'(r), 128'(48));

        // R12 write side end of packet
        mark();
        weop_at = 1;
        wpat = 8'hAA;
        wreg(REG_RADDR, 32'hE00);
        wreg(REG_WADDR, 32'hF00);
        wreg(REG_LEN, 32'd64);
        wreg(REG_CTRL, 32'h22);
        wait_done();
        weop_at = -1;
        wpat = '0;
        rreg(REG_STAT, r);
        chk("R12", "done after write eop", 128'(r), 128'(1));
        chk("R12", "writes", 128'(wcnt - wbase), 128'(2));
        rreg(REG_LEN, r);
        chk("R12", "residual length", 128'(r), 128'(56));
        chk("R12", "requests low", 128'({rd_req, wr_req}), 128'(0));
        mark();
        wreg(REG_RADDR, 32'h40);
        wreg(REG_WADDR, 32'h80);
        wreg(REG_LEN, 32'd4);
        wreg(REG_CTRL, 32'h22);
        wait_done();
        chk("R12", "FIFO discarded", wd_log[wbase], mdata(32'h40));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule